// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides, for each incoming frame, whether its 48-bit destination address lets the frame into the receive path. It keeps a table of up to sixteen exact-match unicast addresses. Software fills the table by passing a 192-byte setup frame through a byte-wide loader port. The frame holds sixteen padded 12-byte entries. Only six bytes of each entry carry address data. Entries that name a group address are dropped, and the unicast ones are packed into the table from slot 0 upward.

A lookup is a single-cycle request carrying the destination address. The verdict appears one cycle later. Three things make the block accept a frame: the promiscuous-mode input is high, the address has its group bit set (multicast or broadcast), or the address equals one of the valid stored entries. A new setup frame is built in a staging copy and replaces the live table in one step once all 192 bytes have arrived. Lookups made during a load therefore still see the old table.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, `match_valid` is 0 and `table_count` is 0, and a unicast destination is rejected while promiscuous mode is off.
- R2: `match_valid` is high in exactly the cycles that follow a cycle with `match_req` high. `match_accept` carries the verdict for that request, so back-to-back requests give back-to-back results.
- R3: A request made with `promisc` high is accepted, whatever its address.
- R4: A destination whose group bit is set is accepted without any table match. The group bit is `match_addr[40]`, the least significant bit of the first address byte, which sits in `match_addr[47:40]`.
- R5: A destination with the group bit clear, and `promisc` low, is accepted only if it equals one of the first `table_count` table entries.
- R6: A setup frame is 192 byte beats forming 16 entries of 12 bytes. Within an entry, the bytes at offsets 0, 1, 4, 5, 8 and 9 become address bytes 0 to 5 in that order, with byte 0 in bits [47:40] and byte 5 in bits [7:0]. The other six bytes of each entry have no effect.
- R7: Entries whose assembled address has the group bit set are skipped. Unicast entries fill slots 0, 1, 2 and so on in frame order. `table_count` becomes the number of unicast entries, from 0 to 16, and an entry in slot 15 matches like any other.
- R8: A completed setup frame replaces the whole previous table and count. Addresses present only in the previous table are rejected afterwards.
- R9: The new table and count take effect for requests sampled two or more clock edges after the edge that takes the 192nd beat. Requests sampled earlier, including those during the load, use the previous table, and `table_count` changes only at that commit.
- R10: A `setup_start` pulse restarts the loader at byte 0 and discards a partly received frame. Bytes presented while no load is active, including beats beyond the 192nd and any beat in the same cycle as `setup_start`, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| setup_start | input | 1 | Pulse that begins a setup-frame load at byte 0 |
| setup_valid | input | 1 | A setup byte is present this cycle |
| setup_byte | input | 8 | Setup-frame byte |
| promisc | input | 1 | Accept every frame when high |
| match_req | input | 1 | Lookup request this cycle |
| match_addr | input | 48 | Destination address, first byte in bits [47:40] |
| match_valid | output | 1 | Verdict valid, one cycle after a request |
| match_accept | output | 1 | 1 accepts the frame, 0 rejects it |
| table_count | output | CNT_W (5) | Number of valid unicast entries in the live table |

## Verification
Every verdict is due in the cycle after the request edge. The bench drives requests on the falling edge and pushes the expected verdict into a queue. A monitor pops that queue on the next falling edge whenever `match_valid` is high, so a late, early or extra result shows up as an order or empty-queue mismatch. A new table counts only from the second edge after the final setup beat: the bench waits out that gap before reading `table_count` or issuing lookups against the new contents. It also places one lookup in the middle of a load to confirm that the old table still answers.

// File: rtl/addr_filter_pkg.sv
package addr_filter_pkg;

  localparam int MAC_W     = 48;
  localparam int MAC_BYTES = 6;
  localparam int GROUP_BIT = MAC_W - 8;

  typedef logic [MAC_W-1:0] mac_t;

  // group (multicast/broadcast) flag: lsb of the first transmitted byte
  function automatic logic is_group(input mac_t a);
    return a[GROUP_BIT];
  endfunction

  // address byte carried by a setup-entry offset, or -1 for padding
  function automatic int addr_lane(input int off);
    int grp;
    int sub;
    grp = off / 4;
    sub = off % 4;
    if (sub < 2 && grp < MAC_BYTES / 2)
      return grp * 2 + sub;
    return -1;
  endfunction

endpackage

// File: rtl/setup_loader.sv
module setup_loader
  import addr_filter_pkg::*;
#(
  parameter int ENTRIES     = 16,
  parameter int ENTRY_BYTES = 12,
  parameter int CNT_W       = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic                          byte_vld,
  input  logic [7:0]                    byte_in,
  output logic [ENTRIES-1:0][MAC_W-1:0] stage_tbl,
  output logic [CNT_W-1:0]              stage_cnt,
  output logic                          commit,
  output logic                          loading
);
  localparam int FRAME_BYTES = ENTRIES * ENTRY_BYTES;
  localparam int IDX_W       = $clog2(FRAME_BYTES);
  localparam int OFF_W       = $clog2(ENTRY_BYTES);
  localparam int SLOT_W      = $clog2(ENTRIES);

  logic [IDX_W-1:0] idx;
  logic [OFF_W-1:0] off;
  mac_t             asm_q;
  mac_t             asm_nx;
  logic             beat;
  logic             entry_end;
  logic             frame_end;
  logic             store;
  int               lane;

  assign beat      = loading && byte_vld && !start;
  assign entry_end = (off == OFF_W'(ENTRY_BYTES - 1));
  assign frame_end = (idx == IDX_W'(FRAME_BYTES - 1));
  assign lane      = addr_lane(int'(off));

  always_comb begin
    asm_nx = asm_q;
    for (int k = 0; k < MAC_BYTES; k++)
      if (lane == k) asm_nx[MAC_W-1-8*k -: 8] = byte_in;
  end

  assign store = beat && entry_end && !is_group(asm_nx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loading   <= 1'b0;
      idx       <= '0;
      off       <= '0;
      asm_q     <= '0;
      stage_cnt <= '0;
      commit    <= 1'b0;
    end else begin
      commit <= 1'b0;
      if (start) begin
        loading   <= 1'b1;
        idx       <= '0;
        off       <= '0;
        asm_q     <= '0;
        stage_cnt <= '0;
      end else if (beat) begin
        asm_q <= asm_nx;
        idx   <= idx + 1'b1;
        off   <= entry_end ? '0 : off + 1'b1;
        if (store) stage_cnt <= stage_cnt + 1'b1;
        if (frame_end) begin
          loading <= 1'b0;
          commit  <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (store) stage_tbl[stage_cnt[SLOT_W-1:0]] <= asm_nx;
  end

endmodule

// File: rtl/addr_table.sv
module addr_table
  import addr_filter_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int CNT_W   = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          commit,
  input  logic [ENTRIES-1:0][MAC_W-1:0] stage_tbl,
  input  logic [CNT_W-1:0]              stage_cnt,
  input  logic                          promisc,
  input  logic                          req,
  input  logic [MAC_W-1:0]              addr,
  output logic                          valid_o,
  output logic                          accept_o,
  output logic [CNT_W-1:0]              count_o,
  output logic [ENTRIES-1:0]            hit_vec
);
  logic [ENTRIES-1:0][MAC_W-1:0] live;
  logic                          accept_d;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hit_vec[i] = (count_o > CNT_W'(i)) && (live[i] == addr);
  end

  assign accept_d = promisc || is_group(addr) || (|hit_vec);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_o  <= '0;
      valid_o  <= 1'b0;
      accept_o <= 1'b0;
    end else begin
      valid_o  <= req;
      accept_o <= req && accept_d;
      if (commit) count_o <= stage_cnt;
    end
  end

  always_ff @(posedge clk) begin
    if (commit) live <= stage_tbl;
  end

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import addr_filter_pkg::*;
#(
  parameter int ENTRIES     = 16,
  parameter int ENTRY_BYTES = 12,
  parameter int CNT_W       = $clog2(ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             setup_start,
  input  logic             setup_valid,
  input  logic [7:0]       setup_byte,
  input  logic             promisc,
  input  logic             match_req,
  input  logic [47:0]      match_addr,
  output logic             match_valid,
  output logic             match_accept,
  output logic [CNT_W-1:0] table_count
);
  logic [ENTRIES-1:0][MAC_W-1:0] stage_tbl;
  logic [CNT_W-1:0]              stage_cnt;
  logic                          commit;
  logic                          loading;
  logic [ENTRIES-1:0]            hit_vec;

  setup_loader #(
    .ENTRIES(ENTRIES), .ENTRY_BYTES(ENTRY_BYTES), .CNT_W(CNT_W)
  ) u_loader (
    .clk(clk), .rst_n(rst_n), .start(setup_start),
    .byte_vld(setup_valid), .byte_in(setup_byte),
    .stage_tbl(stage_tbl), .stage_cnt(stage_cnt),
    .commit(commit), .loading(loading)
  );

  addr_table #(
    .ENTRIES(ENTRIES), .CNT_W(CNT_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n), .commit(commit),
    .stage_tbl(stage_tbl), .stage_cnt(stage_cnt),
    .promisc(promisc), .req(match_req), .addr(match_addr),
    .valid_o(match_valid), .accept_o(match_accept),
    .count_o(table_count), .hit_vec(hit_vec)
  );

endmodule

// File: rtl/rx_addr_filter_chk.sv
module rx_addr_filter_chk #(
  parameter int ENTRIES = 16,
  parameter int CNT_W   = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               promisc,
  input logic               match_req,
  input logic [47:0]        match_addr,
  input logic               match_valid,
  input logic               match_accept,
  input logic [CNT_W-1:0]   table_count,
  input logic               commit,
  input logic               loading,
  input logic [ENTRIES-1:0] hit_vec
);
  AST_RESULT_DUE: assert property (@(posedge clk) disable iff (!rst_n)
    match_req |=> match_valid);                                      // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !match_req |=> !match_valid);                                    // R2
  AST_PROMISC_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (match_req && promisc) |=> match_accept);                        // R3
  AST_GROUP_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (match_req && match_addr[40]) |=> match_accept);                 // R4
  AST_MISS_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (match_req && !promisc && !match_addr[40] && hit_vec == '0)
      |=> !match_accept);                                            // R5
  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    table_count <= CNT_W'(ENTRIES));                                 // R7
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(table_count));                               // R9
  AST_COMMIT_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !loading);                                            // R10
endmodule

bind rx_addr_filter rx_addr_filter_chk #(.ENTRIES(ENTRIES), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .promisc(promisc), .match_req(match_req),
  .match_addr(match_addr), .match_valid(match_valid),
  .match_accept(match_accept), .table_count(table_count),
  .commit(commit), .loading(loading), .hit_vec(hit_vec)
);

// File: tb/tb_rx_addr_filter.sv
`timescale 1ns/1ps
module tb_rx_addr_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        setup_start = 1'b0;
  logic        setup_valid = 1'b0;
  logic [7:0]  setup_byte = '0;
  logic        promisc = 1'b0;
  logic        match_req = 1'b0;
  logic [47:0] match_addr = '0;
  logic        match_valid;
  logic        match_accept;
  logic [4:0]  table_count;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [47:0] ent [16];
  logic [47:0] mdl [$];
  bit          exp_q [$];
  string       tag_q [$];

  always #2 clk = ~clk;

  rx_addr_filter dut (
    .clk(clk), .rst_n(rst_n), .setup_start(setup_start),
    .setup_valid(setup_valid), .setup_byte(setup_byte), .promisc(promisc),
    .match_req(match_req), .match_addr(match_addr),
    .match_valid(match_valid), .match_accept(match_accept),
    .table_count(table_count)
  );

  function automatic logic [47:0] uni(input int n);
    return {8'h02, 8'h10, 8'h20, 8'h30, 8'h40, 8'(n)};
  endfunction

  function automatic bit model_accept(input logic [47:0] a, input bit pr);
    if (pr || a[40]) return 1'b1;
    foreach (mdl[i]) if (mdl[i] == a) return 1'b1;
    return 1'b0;
  endfunction

  // setup byte for frame position b built from ent[]
  function automatic logic [7:0] frame_byte(input int b);
    int e, o, ln;
    e = b / 12;
    o = b % 12;
    case (o)
      0: ln = 0; 1: ln = 1; 4: ln = 2; 5: ln = 3; 8: ln = 4; 9: ln = 5;
      default: ln = -1;
    endcase
    if (ln < 0) return 8'h3C ^ 8'(o);
    return ent[e][47-8*ln -: 8];
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    match_req = 1'b0;
    setup_valid = 1'b0;
    setup_start = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // drive one request cycle; caller ends the burst with idle()
  task automatic lookup(input logic [47:0] a, input bit pr, input string tag);
    match_req = 1'b1;
    match_addr = a;
    promisc = pr;
    exp_q.push_back(model_accept(a, pr));
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  task automatic load(input bit with_start, input int nbytes, input int probe_beat,
                      input logic [47:0] probe_addr);
    if (with_start) begin
      setup_start = 1'b1;
      @(negedge clk);
      setup_start = 1'b0;
    end
    for (int b = 0; b < nbytes; b++) begin
      setup_valid = 1'b1;
      setup_byte = frame_byte(b);
      if (b == probe_beat) begin
        match_req = 1'b1;
        match_addr = probe_addr;
        promisc = 1'b0;
        exp_q.push_back(model_accept(probe_addr, 1'b0));
        tag_q.push_back("R9 lookup during load uses old table");
      end else begin
        match_req = 1'b0;
      end
      @(negedge clk);
    end
    setup_valid = 1'b0;
    match_req = 1'b0;
    if (with_start && nbytes == 192) begin
      mdl.delete();
      for (int e = 0; e < 16; e++) if (!ent[e][40]) mdl.push_back(ent[e]);
    end
    @(negedge clk);
    @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && match_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 result without request", 1, 0);
      end else begin
        bit    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(match_accept == e, t, int'(match_accept), int'(e));
      end
    end
  end

  initial begin
    #(4 * 100000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(match_valid == 1'b0, "R1 match_valid after reset", int'(match_valid), 0);
    check(table_count == 5'd0, "R1 table_count after reset", int'(table_count), 0);
    lookup(uni(1), 1'b0, "R1 unicast rejected with empty table");
    idle(2);

    // frame A: mixed group and unicast entries
    ent[0] = uni(1);
    ent[1] = {8'h01, 8'h00, 8'h5E, 8'h00, 8'h00, 8'h01};
    ent[2] = uni(2);
    ent[3] = 48'hFFFF_FFFF_FFFF;
    for (int e = 4; e < 16; e++) ent[e] = uni(16 + e);
    load(1'b1, 192, -1, '0);
    check(table_count == 5'd14, "R7 count skips group entries", int'(table_count), 14);
    lookup(uni(1), 1'b0, "R6 entry 0 address bytes assembled");
    lookup(uni(2), 1'b0, "R7 compacted entry matches");
    lookup(uni(31), 1'b0, "R7 last entry matches");
    lookup(uni(99), 1'b0, "R5 unknown unicast rejected");
    lookup({8'h03, 8'h3C, 8'h3C, 8'h3C, 8'h3C, 8'h3C}, 1'b0, "R4 group bit accepted");
    lookup(48'hFFFF_FFFF_FFFF, 1'b0, "R4 broadcast accepted");
    lookup(uni(99), 1'b1, "R3 promiscuous accepts unknown");
    lookup({8'h02, 8'h10, 8'h3C, 8'h3D, 8'h40, 8'h01}, 1'b0, "R6 padding bytes ignored");
    idle(3);

    // frame B: sixteen unicast entries, lookup in the middle of the load
    for (int e = 0; e < 16; e++) ent[e] = uni(40 + e);
    load(1'b1, 192, 100, uni(1));
    check(table_count == 5'd16, "R7 full table count", int'(table_count), 16);
    lookup(uni(55), 1'b0, "R7 slot 15 matches");
    lookup(uni(1), 1'b0, "R8 old entry gone after reload");
    lookup(uni(40), 1'b0, "R8 new slot 0 matches");
    idle(3);

    // stray bytes with no load active
    for (int e = 0; e < 16; e++) ent[e] = uni(1);
    load(1'b0, 192, -1, '0);
    check(table_count == 5'd16, "R10 stray bytes leave count", int'(table_count), 16);
    lookup(uni(1), 1'b0, "R10 stray bytes not stored");
    idle(3);

    // restart: partial frame C then full frame D
    for (int e = 0; e < 16; e++) ent[e] = uni(70);
    load(1'b1, 50, -1, '0);
    for (int e = 0; e < 15; e++) ent[e] = {8'h01, 8'hAA, 8'hBB, 8'hCC, 8'hDD, 8'(e)};
    ent[15] = uni(80);
    load(1'b1, 192, -1, '0);
    check(table_count == 5'd1, "R10 restart discards partial frame", int'(table_count), 1);
    lookup(uni(80), 1'b0, "R10 frame after restart matches");
    lookup(uni(70), 1'b0, "R10 partial-frame address rejected");
    idle(3);

    // all-group frame
    for (int e = 0; e < 16; e++) ent[e] = {8'h33, 8'h33, 8'h00, 8'h00, 8'h00, 8'(e)};
    load(1'b1, 192, -1, '0);
    check(table_count == 5'd0, "R7 all-group frame gives zero", int'(table_count), 0);
    lookup(uni(80), 1'b0, "R8 previous entry rejected");
    idle(4);

    check(exp_q.size() == 0, "R2 every request answered", exp_q.size(), 0);
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule